// File: doc/BRIEF.md
# Address Capture Latch with Selectable Trigger

This block sits between a target's address bus and an emulation memory port. During a target access it decides when to freeze the incoming address and, if asked, the two active-low byte-enable lines. It drives the memory port from that frozen copy until the access ends. Outside an access, and before the freeze, the outputs follow the inputs directly.

The three active-low controls pass through a two-flop synchronizer before they are used: chip select, write strobe and output enable. A two-bit trigger-mode field picks the condition that starts a capture. An optional settle delay moves the freeze a programmed number of clocks after the trigger. The delay lets address noise that follows a control edge die down before the value is taken.

The mode and delay settings are copied into a shadow register only while chip select is inactive. Changing them in the middle of an access therefore does nothing until the access ends. Parameters `DEF_MODE`, `DEF_DLY_EN` and `DEF_DLY` set the shadow's reset contents: mode 1, delay enabled, one clock.

Top module: `addr_hold`

## Requirements
- R1: After reset `latched_o` is 0, and `addr_o`, `bhe_o_n` and `ble_o_n` equal their inputs.
- R2: Controls are sampled through two flops. With the delay off (`dly_en_i`=0 or `dly_cnt_i`=0), a trigger condition that is set up before rising edge k freezes the address present at edge k+2. `latched_o` is high from that edge on.
- R3: Mode 0 triggers on chip select active alone, whatever write strobe and output enable do.
- R4: Mode 1 triggers only when chip select and write strobe are both active. Chip select alone does not freeze.
- R5: Mode 2 triggers when chip select is active together with write strobe or output enable. Chip select alone does not freeze.
- R6: Mode 3 triggers on chip select active while output enable is inactive. When synchronized output enable becomes active, the latch turns transparent (`latched_o`=0, `addr_o` follows `addr_i`). It captures again once output enable goes inactive, with the same timing as R2.
- R7: With `dly_en_i`=1 and `dly_cnt_i`=N>0, the freeze happens N clocks later than in R2. The trigger must hold throughout the wait, or the capture is abandoned.
- R8: While `latched_o` is high, `addr_o` keeps the captured value however `addr_i` changes.
- R9: Chip select going inactive before edge k makes `latched_o` drop at edge k+2, and the outputs are transparent from then on.
- R10: With `be_lat_en_i`=1, the byte enables are frozen together with the address. With it 0, `bhe_o_n` and `ble_o_n` follow their inputs even while latched.
- R11: Mode and delay inputs take effect only while synchronized chip select is inactive. A change made during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wt_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | AW | Target address |
| bhe_n | input | 1 | High byte enable in, active low |
| ble_n | input | 1 | Low byte enable in, active low |
| mode_i | input | 2 | Trigger mode: 0 CS, 1 CS&WT, 2 CS&(WT\|OE), 3 CS&!OE |
| dly_en_i | input | 1 | Settle delay enable |
| dly_cnt_i | input | CW | Settle delay in clocks |
| be_lat_en_i | input | 1 | Freeze byte enables with the address |
| addr_o | output | AW | Address to the memory port |
| bhe_o_n | output | 1 | High byte enable out |
| ble_o_n | output | 1 | Low byte enable out |
| latched_o | output | 1 | High while the address is frozen |

## Verification
Each control change reaches the trigger logic two edges after it is driven. With no delay, the freeze and the rise of `latched_o` land on the third rising edge after the change, and N edges later with a delay of N. Release and the mode-3 reopen follow the same three-edge rule. The bench drives every input on a falling edge and counts falling edges to each expected result. For each timed result it checks the falling edge just before the due edge, where the old value must still show, and the one just after, where the new value must appear. After each freeze, the address and byte-enable inputs are changed on purpose to show that the frozen values hold.

// File: rtl/addr_hold_pkg.sv
package addr_hold_pkg;

  typedef enum logic [1:0] {
    TRIG_SEL      = 2'd0,
    TRIG_SEL_WR   = 2'd1,
    TRIG_SEL_RW   = 2'd2,
    TRIG_SEL_NORD = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_HELD = 2'd2
  } cap_state_e;

  // Trigger condition on active-high (already synchronized) controls.
  function automatic logic trig_eval(trig_mode_e m, logic cs, logic wt, logic oe);
    logic r;
    case (m)
      TRIG_SEL:      r = cs;
      TRIG_SEL_WR:   r = cs & wt;
      TRIG_SEL_RW:   r = cs & (wt | oe);
      TRIG_SEL_NORD: r = cs & ~oe;
      default:       r = 1'b0;
    endcase
    return r;
  endfunction

  // Delay is used only when enabled and nonzero.
  function automatic logic dly_active(logic en, int unsigned cnt);
    return en && (cnt != 0);
  endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, STAGES) |-> q_o[b] == $past(d_i[b], STAGES)); // R2
  end
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow
  import addr_hold_pkg::*;
#(
  parameter int CW = 4,
  parameter trig_mode_e DEF_MODE = TRIG_SEL_WR,
  parameter logic DEF_DLY_EN = 1'b1,
  parameter logic [CW-1:0] DEF_DLY = CW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic [1:0]    mode_i,
  input  logic          dly_en_i,
  input  logic [CW-1:0] dly_cnt_i,
  output trig_mode_e    mode_q,
  output logic          dly_en_q,
  output logic [CW-1:0] dly_q
);
  logic load_w;
  assign load_w = ~cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= DEF_MODE;
      dly_en_q <= DEF_DLY_EN;
      dly_q    <= DEF_DLY;
    end else if (load_w) begin
      mode_q   <= trig_mode_e'(mode_i);
      dly_en_q <= dly_en_i;
      dly_q    <= dly_cnt_i;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_act) |-> ($stable(mode_q) && $stable(dly_en_q) && $stable(dly_q))); // R11
endmodule

// File: rtl/capture_ctl.sv
module capture_ctl
  import addr_hold_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          wt_act,
  input  logic          oe_act,
  input  trig_mode_e    mode_q,
  input  logic          dly_en_q,
  input  logic [CW-1:0] dly_q,
  output logic          freeze_o,
  output logic          held_o
);
  cap_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic trig_w, use_dly_w, reopen_w, wait_done_w, abort_w;

  assign trig_w      = trig_eval(mode_q, cs_act, wt_act, oe_act);
  assign use_dly_w   = dly_active(dly_en_q, int'(dly_q));
  assign reopen_w    = (st_q == CAP_HELD) && (mode_q == TRIG_SEL_NORD) && oe_act;
  assign wait_done_w = (st_q == CAP_WAIT) && trig_w && (cnt_q == '0);
  assign abort_w     = (st_q == CAP_WAIT) && !trig_w;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    freeze_o = 1'b0;
    case (st_q)
      CAP_IDLE: begin
        if (trig_w) begin
          if (use_dly_w) begin
            st_d  = CAP_WAIT;
            cnt_d = dly_q - CW'(1);
          end else begin
            st_d     = CAP_HELD;
            freeze_o = 1'b1;
          end
        end
      end
      CAP_WAIT: begin
        if (abort_w) begin
          st_d = CAP_IDLE;
        end else if (wait_done_w) begin
          st_d     = CAP_HELD;
          freeze_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      CAP_HELD: begin
        if (!cs_act || reopen_w) st_d = CAP_IDLE;
      end
      default: st_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CAP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign held_o = (st_q == CAP_HELD);

  AST_FREEZE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> cs_act); // R3
  AST_MODE1_NEEDS_WT: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && mode_q == TRIG_SEL_WR) |-> wt_act); // R4
  AST_MODE2_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && mode_q == TRIG_SEL_RW) |-> (wt_act || oe_act)); // R5
  AST_REOPEN_ON_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && mode_q == TRIG_SEL_NORD && oe_act) |=> !held_o); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_WAIT) |-> (cnt_q < dly_q)); // R7
  AST_RELEASE_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !held_o); // R9
endmodule

// File: rtl/addr_hold.sv
module addr_hold
  import addr_hold_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4,
  parameter trig_mode_e DEF_MODE = TRIG_SEL_WR,
  parameter logic DEF_DLY_EN = 1'b1,
  parameter logic [CW-1:0] DEF_DLY = CW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wt_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_i,
  input  logic          bhe_n,
  input  logic          ble_n,
  input  logic [1:0]    mode_i,
  input  logic          dly_en_i,
  input  logic [CW-1:0] dly_cnt_i,
  input  logic          be_lat_en_i,
  output logic [AW-1:0] addr_o,
  output logic          bhe_o_n,
  output logic          ble_o_n,
  output logic          latched_o
);
  localparam int NCTL = 3;
  localparam int BEW  = 2;

  logic [NCTL-1:0] ctl_raw_n, ctl_s_n;
  logic cs_act, wt_act, oe_act;
  trig_mode_e mode_q;
  logic dly_en_q;
  logic [CW-1:0] dly_q;
  logic freeze_w, held_w;
  logic [AW-1:0] addr_q;
  logic [BEW-1:0] be_i, be_q, be_o;

  assign ctl_raw_n = {oe_n, wt_n, cs_n};

  ctl_sync #(.W(NCTL), .STAGES(2), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw_n), .q_o(ctl_s_n)
  );

  assign cs_act = ~ctl_s_n[0];
  assign wt_act = ~ctl_s_n[1];
  assign oe_act = ~ctl_s_n[2];

  cfg_shadow #(.CW(CW), .DEF_MODE(DEF_MODE), .DEF_DLY_EN(DEF_DLY_EN), .DEF_DLY(DEF_DLY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .mode_i(mode_i), .dly_en_i(dly_en_i), .dly_cnt_i(dly_cnt_i),
    .mode_q(mode_q), .dly_en_q(dly_en_q), .dly_q(dly_q)
  );

  capture_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .wt_act(wt_act), .oe_act(oe_act),
    .mode_q(mode_q), .dly_en_q(dly_en_q), .dly_q(dly_q),
    .freeze_o(freeze_w), .held_o(held_w)
  );

  assign be_i = {bhe_n, ble_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '1;
    end else if (freeze_w) begin
      addr_q <= addr_i;
      be_q   <= be_i;
    end
  end

  assign addr_o    = held_w ? addr_q : addr_i;
  assign latched_o = held_w;

  for (genvar b = 0; b < BEW; b++) begin : g_be
    assign be_o[b] = (be_lat_en_i && held_w) ? be_q[b] : be_i[b];
  end
  assign bhe_o_n = be_o[1];
  assign ble_o_n = be_o[0];

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && $past(latched_o)) |-> $stable(addr_o)); // R8
  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && $past(latched_o) && be_lat_en_i && $past(be_lat_en_i))
      |-> ($stable(bhe_o_n) && $stable(ble_o_n))); // R10
  AST_RISE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> $past(cs_act)); // R2
endmodule

// File: tb/addr_hold_tb.sv
module addr_hold_tb;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wt_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic bhe_n = 1'b1, ble_n = 1'b1;
  logic [1:0] mode_i = 2'd1;
  logic dly_en_i = 1'b0;
  logic [CW-1:0] dly_cnt_i = '0;
  logic be_lat_en_i = 1'b1;
  logic [AW-1:0] addr_o;
  logic bhe_o_n, ble_o_n, latched_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  addr_hold #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wt_n(wt_n), .oe_n(oe_n),
    .addr_i(addr_i), .bhe_n(bhe_n), .ble_n(ble_n), .mode_i(mode_i),
    .dly_en_i(dly_en_i), .dly_cnt_i(dly_cnt_i), .be_lat_en_i(be_lat_en_i),
    .addr_o(addr_o), .bhe_o_n(bhe_o_n), .ble_o_n(ble_o_n), .latched_o(latched_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle_cfg(input logic [1:0] m, input logic de, input logic [CW-1:0] dc);
    cs_n = 1'b1; wt_n = 1'b1; oe_n = 1'b1;
    mode_i = m; dly_en_i = de; dly_cnt_i = dc;
    step(4);
  endtask

  task automatic t_reset();
    addr_i = 16'h1234; bhe_n = 1'b0; ble_n = 1'b1;
    step(1);
    chk("R1", "latched after reset", 32'(latched_o), 0);
    chk("R1", "addr transparent", 32'(addr_o), 32'h1234);
    chk("R1", "bhe transparent", 32'(bhe_o_n), 0);
    chk("R1", "ble transparent", 32'(ble_o_n), 1);
  endtask

  task automatic t_mode0();
    idle_cfg(2'd0, 1'b0, '0);
    addr_i = 16'h0A01; cs_n = 1'b0;
    step(2);
    chk("R2", "not yet latched", 32'(latched_o), 0);
    step(1);
    chk("R3", "cs alone latches", 32'(latched_o), 1);
    chk("R2", "captured addr", 32'(addr_o), 32'h0A01);
    addr_i = 16'h0A02; step(1);
    chk("R8", "hold vs input change", 32'(addr_o), 32'h0A01);
    addr_i = 16'hFFFF; step(2);
    chk("R8", "hold later", 32'(addr_o), 32'h0A01);
    cs_n = 1'b1; step(2);
    chk("R9", "still latched before release edge", 32'(latched_o), 1);
    step(1);
    chk("R9", "released", 32'(latched_o), 0);
    chk("R9", "transparent after release", 32'(addr_o), 32'hFFFF);
  endtask

  task automatic t_mode1();
    idle_cfg(2'd1, 1'b0, '0);
    addr_i = 16'h0B01; cs_n = 1'b0; step(5);
    chk("R4", "cs alone no latch", 32'(latched_o), 0);
    addr_i = 16'h0B02; wt_n = 1'b0; step(3);
    chk("R4", "cs and wt latch", 32'(latched_o), 1);
    chk("R4", "captured addr", 32'(addr_o), 32'h0B02);
    wt_n = 1'b1; addr_i = 16'h0B03; step(4);
    chk("R8", "hold after wt release", 32'(addr_o), 32'h0B02);
    cs_n = 1'b1; step(3);
  endtask

  task automatic t_mode2();
    idle_cfg(2'd2, 1'b0, '0);
    addr_i = 16'h0C01; cs_n = 1'b0; step(5);
    chk("R5", "cs alone no latch", 32'(latched_o), 0);
    oe_n = 1'b0; step(3);
    chk("R5", "cs and oe latch", 32'(latched_o), 1);
    chk("R5", "captured addr", 32'(addr_o), 32'h0C01);
    cs_n = 1'b1; oe_n = 1'b1; step(3);
    idle_cfg(2'd2, 1'b0, '0);
    addr_i = 16'h0C05; cs_n = 1'b0; wt_n = 1'b0; step(3);
    chk("R5", "cs and wt latch", 32'(latched_o), 1);
    chk("R5", "captured addr wt", 32'(addr_o), 32'h0C05);
    cs_n = 1'b1; wt_n = 1'b1; step(3);
  endtask

  task automatic t_mode3();
    idle_cfg(2'd3, 1'b0, '0);
    addr_i = 16'h0D01; cs_n = 1'b0; step(3);
    chk("R6", "cs latches", 32'(latched_o), 1);
    chk("R6", "captured A", 32'(addr_o), 32'h0D01);
    addr_i = 16'h0D02; oe_n = 1'b0; step(2);
    chk("R6", "held before reopen", 32'(addr_o), 32'h0D01);
    step(1);
    chk("R6", "reopened", 32'(latched_o), 0);
    chk("R6", "transparent during oe", 32'(addr_o), 32'h0D02);
    addr_i = 16'h0D03; step(2);
    chk("R6", "burst follows", 32'(addr_o), 32'h0D03);
    oe_n = 1'b1; step(3);
    chk("R6", "recaptured", 32'(latched_o), 1);
    chk("R6", "recaptured addr", 32'(addr_o), 32'h0D03);
    addr_i = 16'h0D04; step(1);
    chk("R8", "hold after recapture", 32'(addr_o), 32'h0D03);
    cs_n = 1'b1; step(3);
  endtask

  task automatic t_delay();
    idle_cfg(2'd0, 1'b1, 4'd4);
    addr_i = 16'h0E01; cs_n = 1'b0; step(6);
    chk("R7", "not latched at N-1", 32'(latched_o), 0);
    step(1);
    chk("R7", "latched after N", 32'(latched_o), 1);
    chk("R7", "captured addr", 32'(addr_o), 32'h0E01);
    cs_n = 1'b1; step(3);
    idle_cfg(2'd0, 1'b1, 4'd0);
    addr_i = 16'h0E02; cs_n = 1'b0; step(3);
    chk("R7", "zero count immediate", 32'(latched_o), 1);
    cs_n = 1'b1; step(3);
    idle_cfg(2'd1, 1'b1, 4'd5);
    cs_n = 1'b0; wt_n = 1'b0; step(4);
    wt_n = 1'b1; step(8);
    chk("R7", "abort when trigger drops", 32'(latched_o), 0);
    cs_n = 1'b1; step(3);
  endtask

  task automatic t_be();
    idle_cfg(2'd0, 1'b0, '0);
    be_lat_en_i = 1'b1; bhe_n = 1'b0; ble_n = 1'b1;
    cs_n = 1'b0; step(3);
    bhe_n = 1'b1; ble_n = 1'b0; step(1);
    chk("R10", "bhe frozen", 32'(bhe_o_n), 0);
    chk("R10", "ble frozen", 32'(ble_o_n), 1);
    be_lat_en_i = 1'b0; step(1);
    chk("R10", "bhe pass when off", 32'(bhe_o_n), 1);
    chk("R10", "ble pass when off", 32'(ble_o_n), 0);
    cs_n = 1'b1; be_lat_en_i = 1'b1; step(3);
  endtask

  task automatic t_cfg();
    idle_cfg(2'd1, 1'b0, '0);
    addr_i = 16'h0F01; cs_n = 1'b0; step(3);
    mode_i = 2'd0; step(5);
    chk("R11", "mode change mid access ignored", 32'(latched_o), 0);
    cs_n = 1'b1; step(4);
    cs_n = 1'b0; step(3);
    chk("R11", "new mode after idle", 32'(latched_o), 1);
    dly_en_i = 1'b1; dly_cnt_i = 4'd6;
    cs_n = 1'b1; step(1);
    dly_en_i = 1'b0; dly_cnt_i = '0; step(4);
    cs_n = 1'b0; step(3);
    chk("R11", "delay setting from idle time", 32'(latched_o), 1);
    cs_n = 1'b1; step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_delay();
    t_be();
    t_cfg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule